// File: doc/BRIEF.md
# SPI Serial Memory Power-Mode Controller

This block sits at the slave side of a serial memory with a SPI interface. It oversamples the serial clock, select and data lines in the system clock domain and shifts in instruction bits MSB first. It keeps a four-valued power mode: standby, active, entering (the programmed wait before the low-power state) and deep power-down. The rest of the memory uses the mode level and a command-block flag to stop write, program and erase instructions whenever the device is entering or sitting in deep power-down.

The power-down instruction (0xB9) is honoured only when select is released on the exact byte boundary after eight bits, and only when no internal erase, program or write cycle is flagged on the busy input. After an accepted power-down, the block counts a programmable number of system clocks before it reports deep power-down. The release instruction (0xAB) returns it to standby from either the wait or the deep state. A one-cycle pulse marks each accepted instruction.

Top module: `spi_pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is standby (`pm_mode` = 2'b00), `cmd_block` is 0 and both acknowledge pulses are 0.
- R2: While select is low and the block is not in the wait or deep state, the mode is active (2'b01). With select high and busy low it returns to standby (2'b00). Input lines take effect after a fixed latency of three system clocks.
- R3: A frame of exactly eight bits carrying 0xB9 (MSB first, bits sampled on the rising serial clock), with busy low, gives a one-cycle `dp_ack` in the first cycle of mode 2'b10 (entering). `cmd_block` is 1 in that mode.
- R4: A 0xB9 frame whose select rises after seven bits, or after nine or more bits, is not accepted: no `dp_ack`, and the mode returns to standby.
- R5: The entering mode lasts exactly `TDP_CYCLES` system clocks and is then followed by mode 2'b11 (deep power-down), with `cmd_block` held at 1.
- R6: In deep power-down, a frame with any first byte other than 0xAB (including 0xB9 and write-type codes) changes neither the mode nor either pulse.
- R7: A frame whose first byte is 0xAB, with eight or more bits, in the deep state gives a one-cycle `wake_ack` and mode standby with `cmd_block` 0. A 0xAB frame shorter than eight bits is ignored.
- R8: A release frame that completes during the entering wait cancels the wait and returns the block to standby with `wake_ack`.
- R9: A valid 0xB9 frame that ends while busy is high is rejected. The mode stays active until busy falls and then goes to standby.
- R10: Busy high with select high holds the mode active. Standby follows only after busy falls.
- R11: A release frame in standby or active produces no `wake_ack` and no change of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the device |
| core_busy | input | 1 | Internal erase, program or write cycle running |
| pm_mode | output | 2 | 00 standby, 01 active, 10 entering, 11 deep power-down |
| cmd_block | output | 1 | High while entering or in deep power-down |
| dp_ack | output | 1 | One-cycle pulse on an accepted power-down |
| wake_ack | output | 1 | One-cycle pulse on an accepted release |

## Verification
On every cycle the assertions check that the two acknowledge pulses never coincide, that each pulse agrees with the mode it leads into, that entering mode is reached only with `dp_ack` and never after busy, that deep power-down follows exactly `TDP_CYCLES` of entering, and that it is left only through `wake_ack`. Only the bench's scenarios can show that frames are judged by their bit count and first byte. These include seven-, eight-, nine- and sixteen-bit frames, a release that arrives during the wait, and non-release opcodes that are ignored while deep. The bench also checks the three-clock input latency against its reference model.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int unsigned OP_BITS = 8;

  typedef enum logic [1:0] {
    PM_STBY  = 2'b00,
    PM_ACT   = 2'b01,
    PM_ENTER = 2'b10,
    PM_DEEP  = 2'b11
  } pm_state_t;

  localparam logic [OP_BITS-1:0] OP_DEEP = 8'hB9;
  localparam logic [OP_BITS-1:0] OP_WAKE = 8'hAB;
endpackage

// File: rtl/pmc_sync.sv
`timescale 1ns/1ps
module pmc_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pmc_shifter.sv
`timescale 1ns/1ps
module pmc_shifter #(
  parameter int unsigned OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sck_s,
  input  logic           cs_n_s,
  input  logic           mosi_s,
  output logic           frame_end,
  output logic           len_exact,
  output logic           len_full,
  output logic           sel,
  output logic [OPW-1:0] opcode
);
  localparam int unsigned CW  = $clog2(OPW + 2);
  localparam logic [CW-1:0] SAT  = CW'(OPW + 1);
  localparam logic [CW-1:0] LAST = CW'(OPW - 1);
  localparam logic [CW-1:0] FULL = CW'(OPW);

  logic           sck_q, cs_q;
  logic [CW-1:0]  cnt, cnt_n;
  logic [OPW-1:0] sh, sh_n, op, op_n;
  logic           sck_rise, cnt_en, sh_en, op_en;

  always_comb begin
    sck_rise = sck_s & ~sck_q;
    sh_n     = {sh[OPW-2:0], mosi_s};
    op_n     = sh_n;
    sh_en    = ~cs_n_s & sck_rise;
    op_en    = sh_en & (cnt == LAST);
    cnt_en   = cs_n_s | (sh_en & (cnt != SAT));
    cnt_n    = cs_n_s ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt   <= '0;
      sh    <= '0;
      op    <= '0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
      if (cnt_en) cnt <= cnt_n;
      if (sh_en)  sh  <= sh_n;
      if (op_en)  op  <= op_n;
    end
  end

  assign frame_end = cs_n_s & ~cs_q;
  assign len_exact = (cnt == FULL);
  assign len_full  = (cnt >= FULL);
  assign sel       = ~cs_n_s;
  assign opcode    = op;
endmodule

// File: rtl/pmc_fsm.sv
`timescale 1ns/1ps
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int unsigned TDP = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic               len_exact,
  input  logic               len_full,
  input  logic               sel,
  input  logic [OP_BITS-1:0] opcode,
  input  logic               busy,
  output pm_state_t          state,
  output logic               dp_ack,
  output logic               wake_ack
);
  localparam int unsigned TW = $clog2(TDP + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TDP - 1);

  pm_state_t     state_n;
  logic [TW-1:0] cnt, cnt_n;
  logic          cnt_en, dp_n, wake_n, deep_ok, wake_ok;

  always_comb begin
    deep_ok = frame_end & len_exact & (opcode == OP_DEEP) & ~busy;
    wake_ok = frame_end & len_full & (opcode == OP_WAKE);
    state_n = state;
    cnt_n   = cnt;
    dp_n    = 1'b0;
    wake_n  = 1'b0;
    case (state)
      PM_STBY, PM_ACT: begin
        if (deep_ok) begin
          state_n = PM_ENTER;
          cnt_n   = '0;
          dp_n    = 1'b1;
        end else begin
          state_n = (sel | busy) ? PM_ACT : PM_STBY;
        end
      end
      PM_ENTER: begin
        if (wake_ok) begin
          state_n = PM_STBY;
          wake_n  = 1'b1;
        end else if (cnt == T_LAST) begin
          state_n = PM_DEEP;
        end else begin
          cnt_n = cnt + TW'(1);
        end
      end
      PM_DEEP: begin
        if (wake_ok) begin
          state_n = PM_STBY;
          wake_n  = 1'b1;
        end
      end
      default: state_n = PM_STBY;
    endcase
    cnt_en = (state_n == PM_ENTER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PM_STBY;
      cnt      <= '0;
      dp_ack   <= 1'b0;
      wake_ack <= 1'b0;
    end else begin
      state    <= state_n;
      if (cnt_en) cnt <= cnt_n;
      dp_ack   <= dp_n;
      wake_ack <= wake_n;
    end
  end
endmodule

// File: rtl/spi_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module spi_pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned TDP_CYCLES  = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic       core_busy,
  output logic [1:0] pm_mode,
  output logic       cmd_block,
  output logic       dp_ack,
  output logic       wake_ack
);
  logic [2:0]         pins_s;
  logic               frame_end, len_exact, len_full, sel;
  logic [OP_BITS-1:0] opcode;
  pm_state_t          state;

  pmc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sck, spi_cs_n, spi_mosi}),
    .q     (pins_s)
  );

  pmc_shifter #(.OPW(OP_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sck_s     (pins_s[2]),
    .cs_n_s    (pins_s[1]),
    .mosi_s    (pins_s[0]),
    .frame_end (frame_end),
    .len_exact (len_exact),
    .len_full  (len_full),
    .sel       (sel),
    .opcode    (opcode)
  );

  pmc_fsm #(.TDP(TDP_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .len_exact (len_exact),
    .len_full  (len_full),
    .sel       (sel),
    .opcode    (opcode),
    .busy      (core_busy),
    .state     (state),
    .dp_ack    (dp_ack),
    .wake_ack  (wake_ack)
  );

  assign pm_mode   = state;
  assign cmd_block = (state == PM_ENTER) || (state == PM_DEEP);
endmodule

// File: rtl/pmc_checker.sv
`timescale 1ns/1ps
module pmc_checker #(
  parameter int unsigned TDP = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       core_busy,
  input logic [1:0] pm_mode,
  input logic       cmd_block,
  input logic       dp_ack,
  input logic       wake_ack
);
  logic [31:0] enter_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                enter_len <= '0;
    else if (pm_mode == 2'b10) enter_len <= enter_len + 32'd1;
    else                       enter_len <= '0;
  end

  assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dp_ack, wake_ack}));

  assert_deep_ack_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dp_ack |-> (pm_mode == 2'b10 && cmd_block));

  assert_enter_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'b10 && $past(pm_mode) != 2'b10) |-> dp_ack);

  assert_block_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_block == pm_mode[1]);

  assert_deep_after_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'b11 && $past(pm_mode) != 2'b11) |-> ($past(pm_mode) == 2'b10 && enter_len == 32'(TDP)));

  assert_deep_exit_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pm_mode) == 2'b11 && pm_mode != 2'b11) |-> wake_ack);

  assert_wake_ack_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |-> (pm_mode == 2'b00 && !cmd_block));

  assert_busy_blocks_deep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dp_ack |-> !$past(core_busy));
endmodule

bind spi_pwr_mode_ctrl pmc_checker #(.TDP(TDP_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .core_busy (core_busy),
  .pm_mode   (pm_mode),
  .cmd_block (cmd_block),
  .dp_ack    (dp_ack),
  .wake_ack  (wake_ack)
);

// File: tb/sim_spi_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_spi_pwr_mode_ctrl;
  localparam int TDP = 120;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, mosi, busy;
  logic [1:0] pm_mode;
  logic cmd_block, dp_ack, wake_ack;

  always #2.5 clk = ~clk;

  spi_pwr_mode_ctrl #(.TDP_CYCLES(TDP)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .core_busy(busy), .pm_mode(pm_mode), .cmd_block(cmd_block),
    .dp_ack(dp_ack), .wake_ack(wake_ack)
  );

  int n_tests = 0, n_fail = 0, dp_seen = 0, rel_seen = 0;
  string cur_req = "R1";
  bit done = 0;

  // Behavioural reference: inputs act after a three-clock latency
  int m_state, m_wait, m_bits;
  logic [7:0] m_sh, m_op;
  bit m_dp, m_rel;
  logic [2:0] hist[$];
  logic [2:0] cur, prv;
  bit fend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_wait = 0; m_bits = 0; m_sh = 0; m_op = 0;
      m_dp = 0; m_rel = 0;
      hist = '{3'b010, 3'b010, 3'b010};
    end else begin
      cur = hist[1]; prv = hist[2];
      fend = cur[1] && !prv[1];
      m_dp = 0; m_rel = 0;
      case (m_state)
        0, 1: if (fend && m_bits == 8 && m_op == 8'hB9 && !busy) begin
                m_state = 2; m_wait = 0; m_dp = 1;
              end else m_state = (!cur[1] || busy) ? 1 : 0;
        2: if (fend && m_bits >= 8 && m_op == 8'hAB) begin m_state = 0; m_rel = 1; end
           else if (m_wait == TDP - 1) m_state = 3;
           else m_wait++;
        default: if (fend && m_bits >= 8 && m_op == 8'hAB) begin m_state = 0; m_rel = 1; end
      endcase
      if (cur[1]) m_bits = 0;
      else if (cur[2] && !prv[2]) begin
        m_sh = {m_sh[6:0], cur[0]};
        m_bits++;
        if (m_bits == 8) m_op = m_sh;
      end
      hist.push_front({sck, cs_n, mosi});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (dp_ack) dp_seen++;
      if (wake_ack) rel_seen++;
      n_tests++;
      if (pm_mode != m_state[1:0] || cmd_block != (m_state >= 2) ||
          dp_ack != m_dp || wake_ack != m_rel) begin
        n_fail++;
        $display("FAIL %s model: actual mode=%0d blk=%0d dp=%0d wk=%0d expected mode=%0d blk=%0d dp=%0d wk=%0d",
                 cur_req, pm_mode, cmd_block, dp_ack, wake_ack, m_state, m_state >= 2, m_dp, m_rel);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] data, input int nbits);
    @(negedge clk); cs_n = 1'b0;
    wait_n(3);
    for (int i = 0; i < nbits; i++) begin
      mosi = data[15-i];
      wait_n(4); sck = 1'b1;
      wait_n(4); sck = 1'b0;
    end
    wait_n(3); cs_n = 1'b1;
    wait_n(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int d0, r0;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0; busy = 1'b0;
    wait_n(4); rst_n = 1'b1;
    wait_n(1);
    cur_req = "R1";
    chk(pm_mode == 2'b00, "R1 mode", pm_mode, 0);
    chk(!cmd_block && !dp_ack && !wake_ack, "R1 flags", {cmd_block, dp_ack, wake_ack}, 0);

    cur_req = "R2";
    cs_n = 1'b0; wait_n(5);
    chk(pm_mode == 2'b01, "R2 active", pm_mode, 1);
    cs_n = 1'b1; wait_n(5);
    chk(pm_mode == 2'b00, "R2 standby", pm_mode, 0);

    cur_req = "R4"; d0 = dp_seen;
    send({8'hB9, 8'h00}, 7);
    send({8'hB9, 8'h80}, 9);
    chk(dp_seen == d0, "R4 no accept", dp_seen - d0, 0);
    chk(pm_mode == 2'b00, "R4 mode", pm_mode, 0);

    cur_req = "R11"; r0 = rel_seen;
    send({8'hAB, 8'h00}, 8);
    chk(rel_seen == r0 && pm_mode == 2'b00, "R11 release idle", rel_seen - r0, 0);

    cur_req = "R10";
    busy = 1'b1; wait_n(3);
    chk(pm_mode == 2'b01, "R10 busy active", pm_mode, 1);
    busy = 1'b0; wait_n(3);
    chk(pm_mode == 2'b00, "R10 standby", pm_mode, 0);

    cur_req = "R9"; d0 = dp_seen;
    busy = 1'b1;
    send({8'hB9, 8'h00}, 8);
    chk(dp_seen == d0, "R9 rejected", dp_seen - d0, 0);
    chk(pm_mode == 2'b01, "R9 held active", pm_mode, 1);
    busy = 1'b0; wait_n(3);
    chk(pm_mode == 2'b00, "R9 standby", pm_mode, 0);

    cur_req = "R3"; d0 = dp_seen;
    send({8'hB9, 8'h00}, 8);
    chk(dp_seen == d0 + 1, "R3 accepted", dp_seen - d0, 1);
    chk(pm_mode == 2'b10 && cmd_block, "R3 entering", pm_mode, 2);

    cur_req = "R5";
    wait_n(TDP + 5);
    chk(pm_mode == 2'b11 && cmd_block, "R5 deep", pm_mode, 3);

    cur_req = "R6"; d0 = dp_seen; r0 = rel_seen;
    send({8'h06, 8'h00}, 8);
    send({8'hB9, 8'h00}, 8);
    chk(pm_mode == 2'b11, "R6 stays deep", pm_mode, 3);
    chk(dp_seen == d0 && rel_seen == r0, "R6 no pulses", dp_seen + rel_seen - d0 - r0, 0);

    cur_req = "R7"; r0 = rel_seen;
    send({8'hAB, 8'h00}, 7);
    chk(pm_mode == 2'b11 && rel_seen == r0, "R7 short release", pm_mode, 3);
    send({8'hAB, 8'h00}, 8);
    chk(rel_seen == r0 + 1, "R7 wake pulse", rel_seen - r0, 1);
    chk(pm_mode == 2'b00 && !cmd_block, "R7 standby", pm_mode, 0);
    send({8'hB9, 8'h00}, 8);
    wait_n(TDP + 5);
    r0 = rel_seen;
    send({8'hAB, 8'h00}, 16);
    chk(rel_seen == r0 + 1 && pm_mode == 2'b00, "R7 long release", pm_mode, 0);

    cur_req = "R8"; r0 = rel_seen;
    send({8'hB9, 8'h00}, 8);
    chk(pm_mode == 2'b10, "R8 waiting", pm_mode, 2);
    send({8'hAB, 8'h00}, 8);
    chk(rel_seen == r0 + 1 && pm_mode == 2'b00, "R8 cancel wait", pm_mode, 0);
    wait_n(TDP + 5);
    chk(pm_mode == 2'b00, "R8 stays standby", pm_mode, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule